// File: doc/BRIEF.md
# Crypto Instruction Macro Sequencer

This block sits between an instruction issue port and the execution port of a crypto coprocessor. It keeps two macro slots. A begin command arms a slot and stores the next N instructions that are accepted, while still passing each one on for execution. An exec command later replays a stored slot N times, one instruction per cycle, into the execution port. While a replay runs, the issue port is stalled.

Two registers report on the block. The status word gives the current state and how many cycles are left in the current sequence. The error word records the security mode that was in force when the last recording or replay started. It also holds a sticky flag for each phase, which sets if the mode moved away from that snapshot while the phase was running. The meaning of the stored instructions is of no concern to the block.

Top module: `cmacro_seq`

## Requirements
- R1: After reset, status and error words read 0, out_valid is low, and both slots are empty, so an exec command on either slot emits nothing.
- R2: An instruction carries its opcode in bits [4:0] and its count immediate in bits [11:8]. Opcodes 5 and 7 are begin commands for slots 0 and 1, and opcodes 6 and 8 are exec commands for slots 0 and 1. Begin and exec commands are consumed and never forwarded. While idle, any other accepted instruction appears on out_valid/out_instr exactly one cycle later.
- R3: A begin command with count N>0 moves the block to recording. The next N accepted instructions, whatever their opcode, are stored in order into the chosen slot and each is forwarded one cycle later. After the Nth, the block is idle again.
- R4: A begin command with count 0 leaves the block idle, stores nothing and is not forwarded.
- R5: An exec command with count M>0 on a slot holding L>0 words emits the slot's words in stored order, one per cycle, M times over (L*M cycles). Each word appears one cycle after it is issued.
- R6: An exec command with count 0, or one aimed at an empty slot, leaves the block idle and emits nothing.
- R7: in_ready is low in every cycle of a replay and high otherwise, so commands offered during a replay wait and are accepted once the block is idle.
- R8: Status bits [1:0] hold the state (0 idle, 1 recording, 2 executing). Bits [7:4] hold the instructions still to capture when recording, the words left in the current pass when executing, and 0 when idle. All other bits are 0.
- R9: Error bits [2:1] take the security mode when a replay starts, and bits [6:5] take it when a recording starts. Bit 0 sets in any executing cycle whose mode differs from bits [2:1]. Bit 4 sets in any recording cycle whose mode differs from bits [6:5]. Bits 3 and 7 read 0.
- R10: The flags are sticky. err_clr[0] clears bit 0 and err_clr[1] clears bit 4. If a set and a clear fall in the same cycle, the set wins.
- R11: Recording into one slot leaves the other slot's contents and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue port instruction valid |
| in_instr | input | 32 | Issue port instruction word |
| in_ready | output | 1 | Issue port may accept this cycle |
| sec_mode | input | 2 | Current security mode (0 non-secure, 1 heavy secure) |
| err_clr | input | 2 | Write-one-to-clear strobes for the two error flags |
| out_valid | output | 1 | Execution port instruction valid |
| out_instr | output | 32 | Execution port instruction word |
| status | output | 16 | State and cycles-left word |
| err_status | output | 8 | Mode snapshots and change flags |

## Verification
The hardest case to reach is an error flag clear that lands in the same cycle as a fresh mode mismatch inside a long replay. The stimulus records a 15-word macro and replays it 15 times, so the replay runs for 225 cycles. Partway through, it switches sec_mode away from the snapshot and pulses the clear strobe while the mismatch persists. A second clear is sent after the replay has ended. Commands are also offered during a replay to exercise the stall. A reference model in the bench compares every output on every cycle.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_EXEC = 2'd2
  } seq_state_e;

  localparam int unsigned OP_W     = 5;
  localparam int unsigned OP_LSB   = 0;
  localparam int unsigned IMM_LSB  = 8;
  localparam int unsigned NSLOT    = 2;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned ERR_W    = 8;
  localparam int unsigned STATUS_W = 16;

  localparam logic [OP_W-1:0] OP_BEGIN0 = 5'd5;
  localparam logic [OP_W-1:0] OP_EXEC0  = 5'd6;
  localparam logic [OP_W-1:0] OP_BEGIN1 = 5'd7;
  localparam logic [OP_W-1:0] OP_EXEC1  = 5'd8;
endpackage

// File: rtl/cmseq_store.sv
module cmseq_store #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned DEPTH   = 16,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic               wr_slot,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic               rd_slot,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [INSTR_W-1:0] rd_data
);
  import cmseq_pkg::*;

  logic [INSTR_W-1:0] slot_rd [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [INSTR_W-1:0] words [DEPTH];
    logic               wr_here;

    assign wr_here = wr_en && (wr_slot == s[0]);

    always_ff @(posedge clk) begin
      if (wr_here) begin
        words[wr_idx] <= wr_data;
      end
    end

    assign slot_rd[s] = words[rd_idx];
  end

  assign rd_data = rd_slot ? slot_rd[1] : slot_rd[0];
endmodule

// File: rtl/cmseq_ctrl.sv
module cmseq_ctrl #(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [cmseq_pkg::OP_W-1:0] op,
  input  logic [CNT_W-1:0]        imm,
  output logic                    in_ready,
  output cmseq_pkg::seq_state_e   state,
  output logic                    cur_slot,
  output logic [CNT_W-1:0]        cyc_left,
  output logic                    wr_en,
  output logic [CNT_W-1:0]        idx,
  output logic                    fwd,
  output logic                    issue,
  output logic                    start_rec,
  output logic                    start_exec
);
  import cmseq_pkg::*;

  seq_state_e       state_q, state_d;
  logic             slot_q, slot_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] reps_q, reps_d;
  logic [CNT_W-1:0] len_q [NSLOT];
  logic [CNT_W-1:0] len_d [NSLOT];

  logic accept, is_begin, is_exec, cmd_slot;

  assign in_ready = (state_q != ST_EXEC);
  assign accept   = in_valid && in_ready;
  assign is_begin = (op == OP_BEGIN0) || (op == OP_BEGIN1);
  assign is_exec  = (op == OP_EXEC0) || (op == OP_EXEC1);
  assign cmd_slot = (op == OP_BEGIN1) || (op == OP_EXEC1);

  always_comb begin
    state_d    = state_q;
    slot_d     = slot_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    reps_d     = reps_q;
    len_d      = len_q;
    wr_en      = 1'b0;
    fwd        = 1'b0;
    issue      = 1'b0;
    start_rec  = 1'b0;
    start_exec = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (is_begin) begin
            if (imm != '0) begin
              state_d         = ST_REC;
              slot_d          = cmd_slot;
              cnt_d           = imm;
              idx_d           = '0;
              len_d[cmd_slot] = imm;
              start_rec       = 1'b1;
            end
          end else if (is_exec) begin
            if ((imm != '0) && (len_q[cmd_slot] != '0)) begin
              state_d    = ST_EXEC;
              slot_d     = cmd_slot;
              idx_d      = '0;
              reps_d     = imm;
              start_exec = 1'b1;
            end
          end else begin
            fwd = 1'b1;
          end
        end
      end
      ST_REC: begin
        if (accept) begin
          wr_en = 1'b1;
          fwd   = 1'b1;
          idx_d = idx_q + 1'b1;
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_EXEC: begin
        issue = 1'b1;
        if (idx_q == len_q[slot_q] - 1'b1) begin
          idx_d  = '0;
          reps_d = reps_q - 1'b1;
          if (reps_q == CNT_W'(1)) begin
            state_d = ST_IDLE;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      reps_q  <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        len_q[s] <= '0;
      end
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      reps_q  <= reps_d;
      len_q   <= len_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_REC:  cyc_left = cnt_q;
      ST_EXEC: cyc_left = len_q[slot_q] - idx_q;
      default: cyc_left = '0;
    endcase
  end

  assign state    = state_q;
  assign cur_slot = slot_q;
  assign idx      = idx_q;

  // R3: the last captured word returns the block to idle
  p_rec_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REC && accept && cnt_q == CNT_W'(1)) |=> (state_q == ST_IDLE));

  // R4: a zero-count begin never leaves idle
  p_zero_begin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && accept && is_begin && imm == '0) |=> (state_q == ST_IDLE));

  // R6: a zero-count exec or an exec on an empty slot stays idle
  p_empty_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && accept && is_exec && (imm == '0 || len_q[cmd_slot] == '0))
      |=> (state_q == ST_IDLE));

  // R8: a running replay always has words left in its pass
  p_exec_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> (cyc_left != '0));
endmodule

// File: rtl/cmseq_errcap.sv
module cmseq_errcap (
  input  logic                              clk,
  input  logic                              rst_n,
  input  cmseq_pkg::seq_state_e             state,
  input  logic                              start_rec,
  input  logic                              start_exec,
  input  logic [cmseq_pkg::MODE_W-1:0]      sec_mode,
  input  logic [1:0]                        err_clr,
  output logic [cmseq_pkg::ERR_W-1:0]       err
);
  import cmseq_pkg::*;

  logic [ERR_W-1:0] err_q, err_d;
  logic             exec_mis, rec_mis;

  assign exec_mis = (state == ST_EXEC) && (sec_mode != err_q[2:1]);
  assign rec_mis  = (state == ST_REC) && (sec_mode != err_q[6:5]);

  always_comb begin
    err_d = err_q;
    if (err_clr[0]) err_d[0] = 1'b0;
    if (err_clr[1]) err_d[4] = 1'b0;
    if (exec_mis)   err_d[0] = 1'b1;
    if (rec_mis)    err_d[4] = 1'b1;
    if (start_exec) err_d[2:1] = sec_mode;
    if (start_rec)  err_d[6:5] = sec_mode;
    err_d[3] = 1'b0;
    err_d[7] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else begin
      err_q <= err_d;
    end
  end

  assign err = err_q;

  // R10: flags hold until their clear strobe
  p_sticky_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[0] && !err_clr[0]) |=> err_q[0]);
  p_sticky_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[4] && !err_clr[1]) |=> err_q[4]);

  // R9: a mode mismatch while recording is recorded next cycle
  p_rec_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REC && sec_mode != err_q[6:5]) |=> err_q[4]);
endmodule

// File: rtl/cmacro_seq.sv
module cmacro_seq #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned DEPTH   = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               in_ready,
  input  logic [1:0]         sec_mode,
  input  logic [1:0]         err_clr,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr,
  output logic [15:0]        status,
  output logic [7:0]         err_status
);
  import cmseq_pkg::*;

  seq_state_e         state;
  logic               cur_slot, wr_en, fwd, issue, start_rec, start_exec;
  logic [CNT_W-1:0]   cyc_left, idx;
  logic [INSTR_W-1:0] rd_data;
  logic               out_valid_q;
  logic [INSTR_W-1:0] out_instr_q;

  cmseq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (in_instr[OP_LSB +: OP_W]),
    .imm        (in_instr[IMM_LSB +: CNT_W]),
    .in_ready   (in_ready),
    .state      (state),
    .cur_slot   (cur_slot),
    .cyc_left   (cyc_left),
    .wr_en      (wr_en),
    .idx        (idx),
    .fwd        (fwd),
    .issue      (issue),
    .start_rec  (start_rec),
    .start_exec (start_exec)
  );

  cmseq_store #(.INSTR_W(INSTR_W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_slot (cur_slot),
    .wr_idx  (idx),
    .wr_data (in_instr),
    .rd_slot (cur_slot),
    .rd_idx  (idx),
    .rd_data (rd_data)
  );

  cmseq_errcap errcap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .start_rec  (start_rec),
    .start_exec (start_exec),
    .sec_mode   (sec_mode),
    .err_clr    (err_clr),
    .err        (err_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_instr_q <= '0;
    end else begin
      out_valid_q <= fwd || issue;
      if (fwd || issue) begin
        out_instr_q <= issue ? rd_data : in_instr;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_instr = out_instr_q;

  always_comb begin
    status                 = '0;
    status[1:0]            = state;
    status[4 +: CNT_W]     = cyc_left;
  end

  // R7: every replay cycle yields an instruction at the execution port
  p_exec_emits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |=> out_valid);

  // R7: the issue port is stalled for the whole replay
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |-> !in_ready);
endmodule

// File: tb/cmacro_seq_tb.sv
module cmacro_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        in_ready;
  logic [1:0]  sec_mode = 2'd0;
  logic [1:0]  err_clr = 2'd0;
  logic        out_valid;
  logic [31:0] out_instr;
  logic [15:0] status;
  logic [7:0]  err_status;

  int n_checks = 0;
  int n_fail = 0;
  bit running = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  cmacro_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_ready(in_ready), .sec_mode(sec_mode), .err_clr(err_clr),
    .out_valid(out_valid), .out_instr(out_instr), .status(status),
    .err_status(err_status)
  );

  // reference model
  int          m_st, m_slot, m_cnt, m_idx, m_reps;
  int          m_len [2];
  logic [31:0] m_mem [2][16];
  bit          m_ov;
  logic [31:0] m_oi;
  logic [7:0]  m_err;

  always @(posedge clk or negedge rst_n) begin : model
    int op, imm, sl;
    bit acc, s0, s4, nov;
    logic [31:0] noi;
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_cnt = 0; m_idx = 0; m_reps = 0;
      m_len[0] = 0; m_len[1] = 0; m_ov = 0; m_oi = '0; m_err = '0;
    end else begin
      op  = int'(in_instr[4:0]);
      imm = int'(in_instr[11:8]);
      sl  = (op == 7 || op == 8) ? 1 : 0;
      acc = in_valid && (m_st != 2);
      s0  = (m_st == 2) && (sec_mode != m_err[2:1]);
      s4  = (m_st == 1) && (sec_mode != m_err[6:5]);
      if (err_clr[0]) m_err[0] = 1'b0;
      if (err_clr[1]) m_err[4] = 1'b0;
      if (s0) m_err[0] = 1'b1;
      if (s4) m_err[4] = 1'b1;
      nov = 0; noi = '0;
      case (m_st)
        0: if (acc) begin
          if (op == 5 || op == 7) begin
            if (imm != 0) begin
              m_st = 1; m_slot = sl; m_cnt = imm; m_idx = 0; m_len[sl] = imm;
              m_err[6:5] = sec_mode;
            end
          end else if (op == 6 || op == 8) begin
            if (imm != 0 && m_len[sl] != 0) begin
              m_st = 2; m_slot = sl; m_idx = 0; m_reps = imm;
              m_err[2:1] = sec_mode;
            end
          end else begin
            nov = 1; noi = in_instr;
          end
        end
        1: if (acc) begin
          m_mem[m_slot][m_idx] = in_instr;
          nov = 1; noi = in_instr;
          m_idx++; m_cnt--;
          if (m_cnt == 0) m_st = 0;
        end
        default: begin
          nov = 1; noi = m_mem[m_slot][m_idx];
          m_idx++;
          if (m_idx == m_len[m_slot]) begin
            m_idx = 0; m_reps--;
            if (m_reps == 0) m_st = 0;
          end
        end
      endcase
      m_ov = nov; m_oi = noi;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin : compare
    logic [15:0] exp_st;
    int cyc;
    if (rst_n && running) begin
      cyc = (m_st == 1) ? m_cnt : (m_st == 2) ? (m_len[m_slot] - m_idx) : 0;
      exp_st = 16'(m_st) | 16'(cyc << 4);
      chk(out_valid === m_ov, cur_req, "out_valid", 32'(out_valid), 32'(m_ov));
      if (m_ov) chk(out_instr === m_oi, cur_req, "out_instr", out_instr, m_oi);
      chk(in_ready === (m_st != 2), "R7", "in_ready", 32'(in_ready), 32'(m_st != 2));
      chk(status === exp_st, "R8", "status", 32'(status), 32'(exp_st));
      chk(err_status === m_err, "R9", "err_status", 32'(err_status), 32'(m_err));
    end
  end

  function automatic logic [31:0] mk(input int op, input int imm, input int pay);
    return {pay[19:0], imm[3:0], 3'b000, op[4:0]};
  endfunction

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_instr = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: explicit reset values
    chk(status === 16'h0, "R1", "reset status", 32'(status), 32'h0);
    chk(err_status === 8'h0, "R1", "reset err", 32'(err_status), 32'h0);
    chk(out_valid === 1'b0, "R1", "reset out_valid", 32'(out_valid), 32'h0);
    running = 1'b1;
    cur_req = "R1";
    send(mk(6, 3, 1)); send(mk(8, 2, 2)); idle(3);

    cur_req = "R2";
    send(mk(1, 0, 16'h1234)); send(mk(11, 9, 16'h0bad)); send(mk(31, 15, 7)); idle(2);

    cur_req = "R3";
    send(mk(5, 3, 0));
    send(mk(1, 0, 16'ha001)); idle(1);
    send(mk(7, 2, 16'ha002));          // recorded verbatim
    send(mk(12, 4, 16'ha003)); idle(2);

    cur_req = "R4";
    send(mk(5, 0, 0)); send(mk(2, 0, 16'hb001)); idle(2);

    cur_req = "R5";
    send(mk(6, 2, 0));
    send(mk(5, 1, 0));                 // R7: stalled until replay ends
    send(mk(3, 0, 16'hc001)); idle(2);
    send(mk(6, 1, 0)); idle(3);

    cur_req = "R6";
    send(mk(6, 0, 0)); send(mk(8, 5, 0)); idle(3);

    cur_req = "R11";
    send(mk(7, 2, 0)); send(mk(1, 0, 16'hd001)); send(mk(1, 0, 16'hd002));
    send(mk(6, 1, 0)); idle(4);
    send(mk(8, 3, 0)); idle(8);

    cur_req = "R9";
    sec_mode = 2'd0;
    send(mk(5, 4, 0)); send(mk(1, 0, 16'he001));
    sec_mode = 2'd1;
    send(mk(1, 0, 16'he002)); send(mk(1, 0, 16'he003)); send(mk(1, 0, 16'he004));
    idle(2);
    send(mk(6, 2, 0)); idle(2);
    sec_mode = 2'd0; idle(8);

    cur_req = "R10";
    err_clr = 2'b11; idle(1); err_clr = 2'b00; idle(2);
    sec_mode = 2'd1;
    send(mk(7, 15, 0));
    for (int i = 0; i < 15; i++) send(mk(1, 0, 16'hf000 + i));
    send(mk(8, 15, 0)); idle(20);
    sec_mode = 2'd0; idle(2);
    err_clr = 2'b01; idle(1); err_clr = 2'b00;   // set wins over clear
    idle(230);
    err_clr = 2'b01; idle(1); err_clr = 2'b00; idle(3);
    running = 1'b0;
    finish_run();
  end
endmodule